// File: doc/BRIEF.md
# Three-Register Interleaving Store Sequencer

This block executes one already-decoded vector store of three-element structures. It takes the command's fields and the current values of the base and index general registers. It then reads three 64-bit vector registers through a read port and writes their elements to a byte-addressed memory port, one element per cycle. The elements go out structure by structure: element e of the first register, then element e of the second, then element e of the third, and then element e+1. After the last write the block presents the updated base-register value, if the command asks for one, and then pulses done.

Before any write, the command is screened. Reserved encodings report undefined. An out-of-range register group or a base register of 15 reports unpredictable. A base address that misses a requested 8-byte alignment reports an alignment fault. In all three cases the command ends with no memory writes and no writeback.

Top module: `tri_interleave_store`

## Requirements
- R1: Size code 00 selects 8-bit elements, 01 selects 16-bit and 10 selects 32-bit. Each register holds 8/eb elements, where eb is the element byte count, so a command makes 3*(8/eb) writes. Each write enables exactly eb bytes.
- R2: The command is undefined, and ends with only undef_o on done and no writes or writeback, when any of these holds: the size code is 11, bit 1 of the alignment code is 1, or the type code is neither 0100 nor 0101. Undefined outranks every other status.
- R3: The first register is {cmd_dhi_i, cmd_vd_i}. Type 0100 uses registers d, d+1, d+2. Type 0101 uses registers d, d+2, d+4.
- R4: A command that is not undefined is unpredictable when the base register number is 15 or when the third register number is above 31. It then ends with only unpred_o, no writes and no writeback. Unpredictable outranks an alignment fault.
- R5: When bit 0 of the alignment code is 1, a base whose low three bits are not zero ends the command with only align_fault_o, no writes and no writeback. When that bit is 0, any byte address is accepted.
- R6: Write i of the command (i = 3e + r) goes to base + i*eb, computed modulo 2^32.
- R7: The data of write i is element e of register r, taken from bits [e*w+w-1 : e*w] of that register, where w = 8*eb. Byte k of the element sits in bus lane (addr[2:0]+k) mod 8, and mem_be_o marks those same lanes. All other data lanes are zero.
- R8: Index field 15 gives no writeback (wb_valid_o stays low). Index field 13 gives base+24. Any other value gives base + index_val_i. All sums wrap modulo 2^32.
- R9: cmd_ready_o is high only while idle, and a command offered while busy is ignored. Writes occupy the N consecutive cycles that follow acceptance. The writeback cycle comes next, and done_o pulses for one cycle after that. A rejected command pulses done_o in the cycle after acceptance.
- R10: undef_o, unpred_o and align_fault_o are high only while done_o is high, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken this cycle if offered |
| cmd_size_i | input | 2 | Element size code |
| cmd_align_i | input | 2 | Alignment code |
| cmd_type_i | input | 4 | Register spacing code |
| cmd_dhi_i | input | 1 | High bit of first register number |
| cmd_vd_i | input | 4 | Low bits of first register number |
| cmd_rn_i | input | 4 | Base register number |
| cmd_rm_i | input | 4 | Index register number / writeback mode |
| base_val_i | input | 32 | Base register contents |
| index_val_i | input | 32 | Index register contents |
| vreg_raddr_o | output | 5 | Vector register read address |
| vreg_rdata_i | input | 64 | Vector register read data, same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Byte address of current element |
| mem_wdata_o | output | 64 | Write data, lanes rotated by address offset |
| mem_be_o | output | 8 | Byte enables |
| wb_valid_o | output | 1 | Base writeback value valid |
| wb_addr_o | output | 32 | New base register value |
| done_o | output | 1 | Command finished, one-cycle pulse |
| undef_o | output | 1 | Undefined encoding status |
| unpred_o | output | 1 | Unpredictable encoding status |
| align_fault_o | output | 1 | Alignment fault status |

## Verification
The bench builds the block with the package defaults: a 32-bit address, 64-bit vector registers and a 32-entry register file. This gives every element size its full element count and lets elements straddle the lane wrap at unaligned bases. It also reaches the boundary where the third register is exactly 31 or just past it, and it makes both the write addresses and the writeback sum wrap past 2^32.

// File: rtl/tis_pkg.sv
package tis_pkg;
  parameter int ADDR_W     = 32;
  parameter int VREG_BYTES = 8;
  parameter int NUM_VREGS  = 32;
  parameter int GPR_IDX_W  = 4;

  localparam int VREG_W = VREG_BYTES * 8;
  localparam int VIDX_W = $clog2(NUM_VREGS);
  localparam int LANE_W = $clog2(VREG_BYTES);

  localparam logic [3:0] TYPE_SINGLE = 4'b0100;
  localparam logic [3:0] TYPE_DOUBLE = 4'b0101;
  localparam logic [GPR_IDX_W-1:0] GPR_NONE  = '1;
  localparam logic [GPR_IDX_W-1:0] GPR_FIXED = GPR_IDX_W'(13);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WB, ST_DONE} state_e;

  typedef struct packed {
    logic [1:0]        size;
    logic [VIDX_W-1:0] reg0;
    logic              dbl;
    logic              undef;
    logic              unpred;
    logic              misalign;
    logic              wback;
    logic              use_index;
  } dec_t;
endpackage

// File: rtl/tis_decode.sv
module tis_decode
  import tis_pkg::*;
(
  input  logic [1:0]           size_i,
  input  logic [1:0]           align_i,
  input  logic [3:0]           type_i,
  input  logic                 dhi_i,
  input  logic [VIDX_W-2:0]    vd_i,
  input  logic [GPR_IDX_W-1:0] rn_i,
  input  logic [GPR_IDX_W-1:0] rm_i,
  input  logic [LANE_W-1:0]    base_lo_i,
  output dec_t                 dec_o
);
  logic [VIDX_W:0] last_reg;
  logic            bad_type;

  always_comb begin
    bad_type        = (type_i != TYPE_SINGLE) && (type_i != TYPE_DOUBLE);
    dec_o.size      = size_i;
    dec_o.reg0      = {dhi_i, vd_i};
    dec_o.dbl       = (type_i == TYPE_DOUBLE);
    last_reg        = {1'b0, dhi_i, vd_i} + (VIDX_W+1)'(dec_o.dbl ? 4 : 2);
    dec_o.undef     = (size_i == 2'b11) || align_i[1] || bad_type;
    dec_o.unpred    = !dec_o.undef &&
                      ((rn_i == GPR_NONE) || (last_reg > (VIDX_W+1)'(NUM_VREGS-1)));
    dec_o.misalign  = !dec_o.undef && !dec_o.unpred && align_i[0] && (base_lo_i != '0);
    dec_o.wback     = (rm_i != GPR_NONE);
    dec_o.use_index = (rm_i != GPR_NONE) && (rm_i != GPR_FIXED);
  end
endmodule

// File: rtl/tis_lane.sv
module tis_lane
  import tis_pkg::*;
(
  input  logic [VREG_W-1:0]     vreg_i,
  input  logic [LANE_W-1:0]     elem_idx_i,
  input  logic [1:0]            size_i,
  input  logic [LANE_W-1:0]     off_i,
  output logic [VREG_W-1:0]     wdata_o,
  output logic [VREG_BYTES-1:0] be_o
);
  logic [LANE_W-1:0] byte_pos;
  logic [LANE_W:0]   nbytes;
  logic [VREG_W-1:0] shifted;

  assign byte_pos = elem_idx_i << size_i;
  assign nbytes   = (LANE_W+1)'(1) << size_i;
  assign shifted  = vreg_i >> {byte_pos, 3'b000};

  // lane b carries element byte (b - off) mod VREG_BYTES
  for (genvar b = 0; b < VREG_BYTES; b++) begin : g_lane
    logic [LANE_W-1:0] src;
    assign src = LANE_W'(b) - off_i;
    assign be_o[b] = ({1'b0, src} < nbytes);
    assign wdata_o[b*8 +: 8] = be_o[b] ? shifted[{src, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/tis_wb.sv
module tis_wb
  import tis_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              use_index_i,
  output logic [ADDR_W-1:0] wb_o
);
  localparam logic [ADDR_W-1:0] FIXED_INC = ADDR_W'(3 * VREG_BYTES);
  assign wb_o = base_i + (use_index_i ? index_i : FIXED_INC);
endmodule

// File: rtl/tri_interleave_store.sv
module tri_interleave_store
  import tis_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [1:0]            cmd_size_i,
  input  logic [1:0]            cmd_align_i,
  input  logic [3:0]            cmd_type_i,
  input  logic                  cmd_dhi_i,
  input  logic [VIDX_W-2:0]     cmd_vd_i,
  input  logic [GPR_IDX_W-1:0]  cmd_rn_i,
  input  logic [GPR_IDX_W-1:0]  cmd_rm_i,
  input  logic [ADDR_W-1:0]     base_val_i,
  input  logic [ADDR_W-1:0]     index_val_i,
  output logic [VIDX_W-1:0]     vreg_raddr_o,
  input  logic [VREG_W-1:0]     vreg_rdata_i,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [VREG_W-1:0]     mem_wdata_o,
  output logic [VREG_BYTES-1:0] mem_be_o,
  output logic                  wb_valid_o,
  output logic [ADDR_W-1:0]     wb_addr_o,
  output logic                  done_o,
  output logic                  undef_o,
  output logic                  unpred_o,
  output logic                  align_fault_o
);
  state_e              state_q;
  dec_t                dec_d, dec_q;
  logic [ADDR_W-1:0]   addr_q, base_q, index_q;
  logic [LANE_W-1:0]   elem_q, elem_last;
  logic [1:0]          slot_q;
  logic [VIDX_W-1:0]   step, reg_off;
  logic                accept, reject;

  tis_decode u_decode (
    .size_i   (cmd_size_i),
    .align_i  (cmd_align_i),
    .type_i   (cmd_type_i),
    .dhi_i    (cmd_dhi_i),
    .vd_i     (cmd_vd_i),
    .rn_i     (cmd_rn_i),
    .rm_i     (cmd_rm_i),
    .base_lo_i(base_val_i[LANE_W-1:0]),
    .dec_o    (dec_d)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign reject      = dec_d.undef || dec_d.unpred || dec_d.misalign;
  assign elem_last   = LANE_W'((VREG_BYTES >> dec_q.size) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      elem_q  <= '0;
      slot_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dec_q   <= dec_d;
          addr_q  <= base_val_i;
          base_q  <= base_val_i;
          index_q <= index_val_i;
          elem_q  <= '0;
          slot_q  <= '0;
          state_q <= reject ? ST_DONE : ST_WRITE;
        end
        ST_WRITE: begin
          addr_q <= addr_q + (ADDR_W'(1) << dec_q.size);
          if (slot_q == 2'd2) begin
            slot_q <= '0;
            if (elem_q == elem_last) state_q <= ST_WB;
            else                     elem_q  <= elem_q + 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        ST_WB:   state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    step = dec_q.dbl ? VIDX_W'(2) : VIDX_W'(1);
    unique case (slot_q)
      2'd0:    reg_off = '0;
      2'd1:    reg_off = step;
      default: reg_off = step << 1;
    endcase
  end
  assign vreg_raddr_o = dec_q.reg0 + reg_off;

  tis_lane u_lane (
    .vreg_i    (vreg_rdata_i),
    .elem_idx_i(elem_q),
    .size_i    (dec_q.size),
    .off_i     (addr_q[LANE_W-1:0]),
    .wdata_o   (mem_wdata_o),
    .be_o      (mem_be_o)
  );

  tis_wb u_wb (
    .base_i     (base_q),
    .index_i    (index_q),
    .use_index_i(dec_q.use_index),
    .wb_o       (wb_addr_o)
  );

  assign mem_we_o      = (state_q == ST_WRITE);
  assign mem_addr_o    = addr_q;
  assign wb_valid_o    = (state_q == ST_WB) && dec_q.wback;
  assign done_o        = (state_q == ST_DONE);
  assign undef_o       = done_o && dec_q.undef;
  assign unpred_o      = done_o && dec_q.unpred;
  assign align_fault_o = done_o && dec_q.misalign;
endmodule

// File: rtl/tis_checker.sv
module tis_checker
  import tis_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_valid_i,
  input logic                  cmd_ready_o,
  input logic                  mem_we_o,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [VREG_BYTES-1:0] mem_be_o,
  input logic                  wb_valid_o,
  input logic                  done_o,
  input logic                  undef_o,
  input logic                  unpred_o,
  input logic                  align_fault_o
);
  logic any_flag;
  assign any_flag = undef_o || unpred_o || align_fault_o;

  assert_busy_no_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !cmd_ready_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wb_then_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> done_o);

  assert_flags_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flag |-> done_o);

  assert_flags_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, unpred_o, align_fault_o}));

  // R4, R5 share this: a rejected command finishes right after acceptance
  assert_reject_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flag |-> $past(cmd_valid_i && cmd_ready_o));

  assert_be_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == 4));

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      mem_addr_o == $past(mem_addr_o) + ADDR_W'($countones(mem_be_o)));
endmodule

bind tri_interleave_store tis_checker u_tis_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .wb_valid_o   (wb_valid_o),
  .done_o       (done_o),
  .undef_o      (undef_o),
  .unpred_o     (unpred_o),
  .align_fault_o(align_fault_o)
);

// File: tb/tri_interleave_store_bench.sv
`timescale 1ns/1ps
module tri_interleave_store_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_size = '0, cmd_align = '0;
  logic [3:0]  cmd_type = 4'b0100;
  logic        cmd_dhi = 1'b0;
  logic [3:0]  cmd_vd = '0, cmd_rn = '0, cmd_rm = 4'hF;
  logic [31:0] base_val = '0, index_val = '0;
  logic [4:0]  vreg_raddr;
  logic [63:0] vreg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        wb_valid, done, undef, unpred, afault;
  logic [31:0] wb_addr;

  logic [63:0] vr [32];
  always_comb vreg_rdata = vr[vreg_raddr];

  tri_interleave_store u_tri_interleave_store (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_size_i(cmd_size), .cmd_align_i(cmd_align), .cmd_type_i(cmd_type),
    .cmd_dhi_i(cmd_dhi), .cmd_vd_i(cmd_vd), .cmd_rn_i(cmd_rn), .cmd_rm_i(cmd_rm),
    .base_val_i(base_val), .index_val_i(index_val),
    .vreg_raddr_o(vreg_raddr), .vreg_rdata_i(vreg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .done_o(done),
    .undef_o(undef), .unpred_o(unpred), .align_fault_o(afault)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // captured run results
  logic [31:0] c_addr [32];
  logic [63:0] c_data [32];
  logic [7:0]  c_be   [32];
  int          c_cyc  [32];
  int          c_n, c_wbcyc, c_donecyc;
  bit          c_wb, c_rdy_bad;
  logic [31:0] c_wbv;
  logic [2:0]  c_flags;

  task automatic run(input logic [1:0] sz, input logic [1:0] al, input logic [3:0] ty,
                     input logic [4:0] d, input logic [3:0] rn, input logic [3:0] rm,
                     input logic [31:0] base, input logic [31:0] idx, input bit poke);
    @(negedge clk);
    cmd_size = sz; cmd_align = al; cmd_type = ty; cmd_dhi = d[4]; cmd_vd = d[3:0];
    cmd_rn = rn; cmd_rm = rm; base_val = base; index_val = idx; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    c_n = 0; c_wb = 0; c_wbcyc = 0; c_donecyc = 0; c_rdy_bad = 0; c_flags = '0; c_wbv = '0;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 2) begin
        cmd_valid = 1'b1; cmd_size = 2'b00; cmd_type = 4'b0100; cmd_vd = 4'd0;
        base_val = 32'h5555_0000;
      end
      if (mem_we && c_n < 32) begin
        c_addr[c_n] = mem_addr; c_data[c_n] = mem_wdata; c_be[c_n] = mem_be;
        c_cyc[c_n] = cyc; c_n++;
      end
      if (cmd_ready) c_rdy_bad = 1;
      if (wb_valid) begin c_wb = 1; c_wbv = wb_addr; c_wbcyc = cyc; end
      if (done) begin
        c_donecyc = cyc; c_flags = {undef, unpred, afault};
        cmd_valid = 1'b0;
        break;
      end
    end
    cmd_valid = 1'b0;
  endtask

  function automatic logic [63:0] rotl64(input logic [63:0] x, input int s);
    return (s == 0) ? x : ((x << s) | (x >> (64 - s)));
  endfunction

  task automatic check_ok(input string tag, input logic [1:0] sz, input logic [3:0] ty,
                          input logic [4:0] d, input logic [3:0] rm,
                          input logic [31:0] base, input logic [31:0] idx);
    int eb = 1 << sz;
    int n = 3 * (8 / eb);
    int inc = (ty == 4'b0101) ? 2 : 1;
    int bad_a = 0, bad_d = 0, bad_c = 0;
    logic [31:0] ea, fa = '0, fea = '0;
    logic [63:0] ed, fd = '0, fed = '0;
    logic [7:0]  eby;
    chk(c_n == n, "R1", $sformatf("%s write count", tag), 64'(c_n), 64'(n));
    for (int i = 0; i < n && i < c_n; i++) begin
      int e = i / 3;
      int r = i % 3;
      int w = 8 * eb;
      logic [63:0] elem = (vr[d + r * inc] >> (e * w)) & ((64'h1 << w) - 1);
      logic [7:0]  m = 8'((1 << eb) - 1);
      ea  = base + 32'(i * eb);
      ed  = rotl64(elem, 8 * int'(ea[2:0]));
      eby = 8'(rotl64({56'h0, m}, int'(ea[2:0])) | (rotl64({56'h0, m}, int'(ea[2:0])) >> 8));
      if (c_addr[i] != ea) begin if (bad_a == 0) begin fa = c_addr[i]; fea = ea; end bad_a++; end
      if (c_data[i] != ed || c_be[i] != eby) begin
        if (bad_d == 0) begin fd = c_data[i]; fed = ed; end
        bad_d++;
      end
      if (c_cyc[i] != i + 1) bad_c++;
    end
    chk(bad_a == 0, "R6", $sformatf("%s addresses", tag), 64'(fa), 64'(fea));
    chk(bad_d == 0, "R7", $sformatf("%s data/enables (R3 order)", tag), fd, fed);
    chk(bad_c == 0 && !c_rdy_bad, "R9", $sformatf("%s write cycles/ready", tag),
        64'(bad_c), 64'(0));
    if (rm == 4'hF) begin
      chk(!c_wb, "R8", $sformatf("%s no writeback", tag), 64'(c_wb), 64'(0));
    end else begin
      logic [31:0] ew = base + ((rm == 4'd13) ? 32'd24 : idx);
      chk(c_wb && c_wbv == ew, "R8", $sformatf("%s writeback value", tag), 64'(c_wbv), 64'(ew));
      chk(c_wbcyc == n + 1, "R9", $sformatf("%s writeback cycle", tag), 64'(c_wbcyc), 64'(n + 1));
    end
    chk(c_donecyc == n + 2, "R9", $sformatf("%s done cycle", tag), 64'(c_donecyc), 64'(n + 2));
    chk(c_flags == 3'b000, "R10", $sformatf("%s status clear", tag), 64'(c_flags), 64'(0));
  endtask

  task automatic check_err(input string tag, input logic [2:0] exp_flags);
    chk(c_n == 0 && !c_wb, tag, "no write or writeback", 64'(c_n), 64'(0));
    chk(c_donecyc == 1, tag, "done cycle", 64'(c_donecyc), 64'(1));
    chk(c_flags == exp_flags, tag, "status {undef,unpred,align}", 64'(c_flags), 64'(exp_flags));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready && !mem_we && !done && !wb_valid, "R9", "reset idle",
        {60'h0, cmd_ready, mem_we, done, wb_valid}, 64'h8);
    chk({undef, unpred, afault} == 3'b000, "R10", "reset status", 64'({undef, unpred, afault}), 64'(0));
  endtask

  task automatic t_byte_single();
    run(2'b00, 2'b00, 4'b0100, 5'd3, 4'd2, 4'd13, 32'h2000_0010, 32'h0, 1'b0);
    check_ok("R1 R3 byte single", 2'b00, 4'b0100, 5'd3, 4'd13, 32'h2000_0010, 32'h0);
  endtask

  task automatic t_half_double_index();
    // unaligned base with no alignment demand (R5); busy poke ignored (R9)
    run(2'b01, 2'b00, 4'b0101, 5'd10, 4'd1, 4'd4, 32'hFFFF_FF03, 32'h0000_0200, 1'b1);
    check_ok("R5 half double", 2'b01, 4'b0101, 5'd10, 4'd4, 32'hFFFF_FF03, 32'h0000_0200);
  endtask

  task automatic t_word_wrap();
    // third register exactly 31 (R4 boundary), aligned base wraps (R6)
    run(2'b10, 2'b01, 4'b0100, 5'd29, 4'd0, 4'hF, 32'hFFFF_FFF8, 32'h0, 1'b0);
    check_ok("R4 word wrap", 2'b10, 4'b0100, 5'd29, 4'hF, 32'hFFFF_FFF8, 32'h0);
  endtask

  task automatic t_undef();
    run(2'b11, 2'b00, 4'b0100, 5'd0, 4'd1, 4'd13, 32'h100, 32'h0, 1'b0);
    check_err("R2", 3'b100);
    run(2'b00, 2'b10, 4'b0100, 5'd0, 4'd1, 4'd13, 32'h100, 32'h0, 1'b0);
    check_err("R2", 3'b100);
    run(2'b00, 2'b00, 4'b0110, 5'd30, 4'hF, 4'd13, 32'h100, 32'h0, 1'b0);
    check_err("R2", 3'b100);
  endtask

  task automatic t_unpred();
    run(2'b00, 2'b00, 4'b0100, 5'd0, 4'hF, 4'd13, 32'h100, 32'h0, 1'b0);
    check_err("R4", 3'b010);
    run(2'b01, 2'b00, 4'b0101, 5'd28, 4'd1, 4'd13, 32'h100, 32'h0, 1'b0);
    check_err("R4", 3'b010);
    run(2'b00, 2'b01, 4'b0100, 5'd30, 4'd1, 4'd13, 32'h103, 32'h0, 1'b0);
    check_err("R4", 3'b010);
  endtask

  task automatic t_misalign();
    run(2'b10, 2'b01, 4'b0100, 5'd0, 4'd1, 4'd13, 32'h0000_1004, 32'h0, 1'b0);
    check_err("R5", 3'b001);
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      for (int b = 0; b < 8; b++) vr[i][b*8 +: 8] = 8'(i * 8 + b);
    #9 rst_n = 1'b1;
    t_reset();
    t_byte_single();
    t_half_double_index();
    t_word_wrap();
    t_undef();
    t_unpred();
    t_misalign();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule